// File: doc/BRIEF.md
# I2C Bus Condition Sequencer

This block is the master-side front end that puts START and STOP conditions on a two-wire I2C bus. Software-style register writes drive it. A control register holds an enable bit and a clock-mode bit. A write to the status register launches a condition; the combination of bits in that write decides whether it is a START or a STOP. Every setup and hold interval is an exact count of system-clock cycles, and the count depends on the clock mode. A bus-busy flag follows each condition after a fixed delay, measured from the write.

After a START, the sequencer clears its 3-bit bit counter and clocks out one byte's worth of SCL pulses, with SDA held low. It then parks with SCL held low, which is the "transfer active" state, and waits for a STOP. Both lines are modelled as pull-down enables, and an external pull-up is assumed. The sampled SCL input lets a slave stretch the high phase of each pulse.

States: `S_IDLE` (bus released), `S_START_SU` (START setup, both lines high), `S_START_HD` (START hold, SDA low, SCL high), `S_BIT_LOW` and `S_BIT_HIGH` (the two halves of each SCL pulse), `S_HELD` (byte done, SCL low), `S_STOP_SU` (STOP setup, SCL high, SDA low). The transitions are:
- IDLE→START_SU on an accepted START.
- START_SU→START_HD when the setup count expires.
- START_HD→BIT_LOW when the hold count expires.
- BIT_LOW→BIT_HIGH when the half period expires.
- BIT_HIGH→BIT_LOW when a half period of sensed-high SCL expires with fewer than 8 bits done.
- BIT_HIGH→HELD when the eighth bit completes.
- HELD→STOP_SU on an accepted STOP.
- STOP_SU→IDLE when the STOP setup count expires.

Top module: `i2c_cond_gen`

## Requirements
- R1: After synchronous reset, `scl_pull`=0, `sda_pull`=0, `busy`=0 and `bit_cnt`=0.
- R2: The control register is written with `wr_addr`=0. Bit 0 of `wr_data` is enable and bit 1 is fast mode. While enable is 0, status writes cause no line activity and no `busy` change.
- R3: The status register is written with `wr_addr`=1, where bit 2 is master, bit 1 is transmit and bit 0 is busy. A write of 3'b111 in standard mode (fast=0) starts a START. With the write sampled at edge E, `sda_pull` rises at E+20 and `scl_pull` rises at E+40.
- R4: In fast mode (fast=1), a START write gives `sda_pull` rising at E+10 and `scl_pull` rising at E+20.
- R5: `busy` rises 12 cycles after an accepted START write in standard mode and 6 cycles after it in fast mode.
- R6: A status write of 3'b110 while a transfer is held starts a STOP. `scl_pull` falls at edge E itself, and `sda_pull` falls at E+17 in standard mode or E+7 in fast mode.
- R7: `busy` falls 12 cycles after an accepted STOP write in standard mode and 6 cycles after it in fast mode.
- R8: After a START, the bit counter is cleared and exactly 8 SCL pulses follow, each a half period low and then a half period high. The half period equals the hold count. The counter increments as SCL is pulled low at the end of each pulse, so it reads 3 after the third pulse and wraps to 0 after the eighth. Both lines then stay pulled low.
- R9: A START write is ignored unless the sequencer is idle, including a write on the very edge that ends a STOP. A STOP write is ignored unless a transfer is held.
- R10: The clock mode is captured when a condition is accepted. Changing the mode bit during a sequence does not alter that sequence's timing.
- R11: The high half of each SCL pulse does not count down while the sampled `scl_in` is low, so a slave holding SCL low stretches it.
- R12: Status writes with any other bit combination (for example 3'b101) are ignored.
- R13: `sda_pull` changes only while SCL is released, both in the cycle before the change and in the cycle of the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = status register |
| wr_data | input | 3 | Write data (field positions in R2 and R3) |
| scl_in | input | 1 | Sensed SCL line level |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| busy | output | 1 | Bus-busy flag |
| bit_cnt | output | 3 | Bit counter |

## Verification
Two functions can fall on the same edge: the STOP setup count expiring, which returns the sequencer to idle, and a fresh START write. The bench places a START write so that it is sampled on exactly the edge where SDA is released. That write must be ignored: no line or busy event may follow it, because the sequencer still sits in STOP setup on that edge. The same coincidence happens inside each pulse, where the bit counter steps on the edge that pulls SCL low. The bench checks this by reading the counter after the third pull, and it also provokes a START write mid-byte that must change nothing.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START_SU,
        S_START_HD,
        S_BIT_LOW,
        S_BIT_HIGH,
        S_HELD,
        S_STOP_SU
    } cond_state_t;

    // control register fields
    localparam int unsigned F_EN   = 0;
    localparam int unsigned F_FAST = 1;
    // status register fields
    localparam int unsigned F_MST  = 2;
    localparam int unsigned F_TRX  = 1;
    localparam int unsigned F_BB   = 0;

    localparam int unsigned BITS_PER_BYTE = 8;

    function automatic int unsigned cmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                  cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (dec && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_busy_tracker.sv
module i2c_busy_tracker #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic [W-1:0] arm_val,
    input  logic         arm_level,
    output logic         busy
);
    logic [W-1:0] cnt;
    logic         pending;
    logic         target;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            pending <= 1'b0;
            target  <= 1'b0;
            busy    <= 1'b0;
        end else if (arm) begin
            cnt     <= arm_val;
            pending <= 1'b1;
            target  <= arm_level;
        end else if (pending) begin
            if (cnt == '0) begin
                busy    <= target;
                pending <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int unsigned STD_START_SU  = 20,
    parameter int unsigned STD_STOP_SU   = 17,
    parameter int unsigned STD_HOLD      = 20,
    parameter int unsigned STD_BB_DLY    = 12,
    parameter int unsigned FAST_START_SU = 10,
    parameter int unsigned FAST_STOP_SU  = 7,
    parameter int unsigned FAST_HOLD     = 10,
    parameter int unsigned FAST_BB_DLY   = 6,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [2:0] wr_data,
    input  logic       scl_in,
    output logic       scl_pull,
    output logic       sda_pull,
    output logic       busy,
    output logic [2:0] bit_cnt
);
    localparam int unsigned MAXC = cmax(cmax(cmax(STD_START_SU, STD_STOP_SU),
                                             cmax(STD_HOLD, STD_BB_DLY)),
                                        cmax(cmax(FAST_START_SU, FAST_STOP_SU),
                                             cmax(FAST_HOLD, FAST_BB_DLY)));
    localparam int unsigned CW = $clog2(MAXC + 1);

    cond_state_t state, nxt;

    logic          en_q, fast_q, mode_fast;
    logic          in_idle, in_held;
    logic          status_wr, start_go, stop_go, fast_sel;
    logic          scl_hi, t_zero, t_load, t_dec;
    logic [CW-1:0] t_val;
    logic [CW-1:0] v_start_su, v_stop_su, v_half, v_bb;

    // ---- control register and captured mode ----
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            fast_q    <= 1'b0;
            mode_fast <= 1'b0;
        end else begin
            if (wr_en && !wr_addr) begin
                en_q   <= wr_data[F_EN];
                fast_q <= wr_data[F_FAST];
            end
            if (start_go || stop_go) mode_fast <= fast_q;
        end
    end

    // ---- command decode ----
    assign in_idle   = (state == S_IDLE);
    assign in_held   = (state == S_HELD);
    assign status_wr = wr_en && wr_addr && en_q && wr_data[F_MST] && wr_data[F_TRX];
    assign start_go  = status_wr &&  wr_data[F_BB] && in_idle;
    assign stop_go   = status_wr && !wr_data[F_BB] && in_held;
    assign fast_sel  = (start_go || stop_go) ? fast_q : mode_fast;

    always_comb begin
        v_start_su = fast_sel ? CW'(FAST_START_SU - 1) : CW'(STD_START_SU - 1);
        v_stop_su  = fast_sel ? CW'(FAST_STOP_SU - 1)  : CW'(STD_STOP_SU - 1);
        v_half     = fast_sel ? CW'(FAST_HOLD - 1)     : CW'(STD_HOLD - 1);
        v_bb       = fast_sel ? CW'(FAST_BB_DLY - 1)   : CW'(STD_BB_DLY - 1);
    end

    // ---- sensed SCL ----
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (scl_in),
        .dout (scl_hi)
    );

    // ---- phase timer ----
    i2c_phase_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .dec      (t_dec),
        .zero     (t_zero)
    );

    // ---- bus-busy flag ----
    i2c_busy_tracker #(.W(CW)) u_busy (
        .clk       (clk),
        .rst       (rst),
        .arm       (start_go || stop_go),
        .arm_val   (v_bb),
        .arm_level (start_go),
        .busy      (busy)
    );

    // ---- next state ----
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        t_dec  = 1'b1;
        unique case (state)
            S_IDLE: begin
                if (start_go) begin
                    nxt    = S_START_SU;
                    t_load = 1'b1;
                    t_val  = v_start_su;
                end
            end
            S_START_SU: begin
                if (t_zero) begin
                    nxt    = S_START_HD;
                    t_load = 1'b1;
                    t_val  = v_half;
                end
            end
            S_START_HD: begin
                if (t_zero) begin
                    nxt    = S_BIT_LOW;
                    t_load = 1'b1;
                    t_val  = v_half;
                end
            end
            S_BIT_LOW: begin
                if (t_zero) begin
                    nxt    = S_BIT_HIGH;
                    t_load = 1'b1;
                    t_val  = v_half;
                end
            end
            S_BIT_HIGH: begin
                t_dec = scl_hi;
                if (t_zero && scl_hi) begin
                    nxt    = (bit_cnt == 3'(BITS_PER_BYTE - 1)) ? S_HELD : S_BIT_LOW;
                    t_load = 1'b1;
                    t_val  = v_half;
                end
            end
            S_HELD: begin
                if (stop_go) begin
                    nxt    = S_STOP_SU;
                    t_load = 1'b1;
                    t_val  = v_stop_su;
                end
            end
            S_STOP_SU: begin
                if (t_zero) nxt = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // ---- state register and bit counter ----
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= nxt;
            if (start_go)
                bit_cnt <= '0;
            else if (state == S_BIT_HIGH && nxt != S_BIT_HIGH)
                bit_cnt <= bit_cnt + 3'd1;
        end
    end

    // ---- line outputs ----
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        unique case (state)
            S_IDLE:     begin scl_pull = 1'b0; sda_pull = 1'b0; end
            S_START_SU: begin scl_pull = 1'b0; sda_pull = 1'b0; end
            S_START_HD: begin scl_pull = 1'b0; sda_pull = 1'b1; end
            S_BIT_LOW:  begin scl_pull = 1'b1; sda_pull = 1'b1; end
            S_BIT_HIGH: begin scl_pull = 1'b0; sda_pull = 1'b1; end
            S_HELD:     begin scl_pull = 1'b1; sda_pull = 1'b1; end
            S_STOP_SU:  begin scl_pull = 1'b0; sda_pull = 1'b1; end
            default:    begin scl_pull = 1'b0; sda_pull = 1'b0; end
        endcase
    end
endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_addr,
    input logic       en_q,
    input logic       in_idle,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic       busy,
    input logic [2:0] bit_cnt
);
    // R13: SDA moves only with SCL released on both sides of the edge
    assert_sda_only_scl_high_R13: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> (!scl_pull && !$past(scl_pull)));

    // R2: a status write while disabled leaves an idle bus untouched
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr && !en_q && in_idle) |=>
            ($stable(sda_pull) && $stable(scl_pull) && $stable(busy) && in_idle));

    // R5: busy rises while both lines are still released
    assert_busy_rise_lines_idle_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!scl_pull && !sda_pull));

    // R7: busy falls during STOP setup, with SCL released and SDA still low
    assert_busy_fall_sda_low_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!scl_pull && sda_pull));

    // R8: the bit counter steps only on an edge that pulls SCL low
    assert_bitcnt_on_scl_fall_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(bit_cnt) |-> $rose(scl_pull));
endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .en_q     (en_q),
    .in_idle  (in_idle),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .busy     (busy),
    .bit_cnt  (bit_cnt)
);

// File: tb/i2c_cond_gen_tb.sv
module i2c_cond_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [2:0] wr_data = 3'b000;
    logic       stretch = 1'b0;
    logic       mark = 1'b0;
    logic       scl_in;
    logic       scl_pull, sda_pull, busy;
    logic [2:0] bit_cnt;

    assign scl_in = !scl_pull && !stretch;

    i2c_cond_gen u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .scl_in   (scl_in),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .busy     (busy),
        .bit_cnt  (bit_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    bit  watch_scl = 1'b1;
    int  since = 0;
    logic p_scl = 1'b0, p_sda = 1'b0, p_busy = 1'b0;

    typedef struct {
        int    kind;   // 0 sda_pull, 1 scl_pull, 2 busy
        logic  val;
        int    dly;
        string req;
    } exp_t;
    exp_t expq[$];

    // cycles since the last accepted (marked) status write
    always @(posedge clk) begin
        if (wr_en && wr_addr && mark) since <= 0;
        else                          since <= since + 1;
    end

    function automatic void note(input int kind, input logic v);
        exp_t e;
        checks++;
        if (expq.size() == 0) begin
            errors++;
            $display("FAIL R9/R12 unexpected change kind %0d to %0b at cycle %0d, expected none",
                     kind, v, since);
        end else begin
            e = expq.pop_front();
            if (e.kind != kind || e.val !== v || e.dly != since) begin
                errors++;
                $display("FAIL %s kind %0d val %0b at cycle %0d, expected kind %0d val %0b at cycle %0d",
                         e.req, kind, v, since, e.kind, e.val, e.dly);
            end
        end
    endfunction

    // monitor: pop and compare every line/flag event
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_pull !== p_sda) begin
                note(0, sda_pull);
                checks++;
                if (scl_pull || p_scl) begin
                    errors++;
                    $display("FAIL R13 sda changed with scl_pull %0b/%0b, expected 0/0", p_scl, scl_pull);
                end
            end
            if (watch_scl && scl_pull !== p_scl) note(1, scl_pull);
            if (busy !== p_busy) note(2, busy);
        end
        p_sda  = sda_pull;
        p_scl  = scl_pull;
        p_busy = busy;
    end

    function automatic void exp_ev(input int k, input logic v, input int d, input string r);
        exp_t e;
        e.kind = k; e.val = v; e.dly = d; e.req = r;
        expq.push_back(e);
    endfunction

    task automatic chk(input string r, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", r, act, expv);
        end
    endtask

    task automatic wr(input logic a, input logic [2:0] d, input logic m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; mark = m;
        @(negedge clk);
        wr_en = 1'b0; mark = 1'b0;
    endtask

    task automatic drain(input string r);
        int n;
        n = 0;
        while (expq.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s %0d events missing, expected 0", r, expq.size());
            expq.delete();
        end
    endtask

    // count one byte of pulses; optional stretch and mid-byte START
    task automatic run_byte(input bit do_stretch);
        int  rises;
        int  n;
        bit  stretched;
        bit  poked;
        logic last;
        rises = 0; n = 0; stretched = 0; poked = 0;
        last = scl_pull;
        watch_scl = 1'b0;
        while (rises < 8 && n < 3000) begin
            @(negedge clk);
            n++;
            wr_en = 1'b0;
            if (scl_pull && !last) begin
                rises++;
                if (rises == 3) chk("R8 bit_cnt after third pulse", int'(bit_cnt), 3);
            end
            last = scl_pull;
            if (rises == 4 && !poked) begin
                poked = 1;
                wr_en = 1'b1; wr_addr = 1'b1; wr_data = 3'b111;  // R9 START mid-byte
            end
            if (do_stretch && rises == 2 && !scl_pull && !stretched) begin
                stretched = 1;
                stretch = 1'b1;
                repeat (30) begin
                    @(negedge clk);
                    wr_en = 1'b0;
                    if (scl_pull && !last) rises++;
                    last = scl_pull;
                end
                chk("R11 scl stays released while stretched", int'(scl_pull), 0);
                chk("R11 no pulse during stretch", rises, 2);
                stretch = 1'b0;
            end
        end
        wr_en = 1'b0;
        repeat (60) begin
            @(negedge clk);
            if (scl_pull && !last) rises++;
            last = scl_pull;
        end
        chk("R8 pulse count", rises, 8);
        chk("R8 bit_cnt wrapped", int'(bit_cnt), 0);
        chk("R8 scl held low", int'(scl_pull), 1);
        chk("R8 sda held low", int'(sda_pull), 1);
        watch_scl = 1'b1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 scl_pull", int'(scl_pull), 0);
        chk("R1 sda_pull", int'(sda_pull), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 bit_cnt", int'(bit_cnt), 0);

        // R2: disabled
        wr(1'b1, 3'b111, 1'b0);
        repeat (60) @(negedge clk);
        chk("R2 busy stays low", int'(busy), 0);

        // enable, standard mode
        wr(1'b0, 3'b001, 1'b0);
        // R9: STOP while idle
        wr(1'b1, 3'b110, 1'b0);
        // R12: bad combination
        wr(1'b1, 3'b101, 1'b0);
        repeat (60) @(negedge clk);
        chk("R9/R12 bus idle", int'(sda_pull), 0);

        // R3/R5: standard START
        exp_ev(2, 1'b1, 12, "R5");
        exp_ev(0, 1'b1, 20, "R3");
        exp_ev(1, 1'b1, 40, "R3");
        wr(1'b1, 3'b111, 1'b1);
        drain("R3");
        run_byte(1'b0);

        // R6/R7: standard STOP; START on the completing edge (R9)
        exp_ev(1, 1'b0, 0, "R6");
        exp_ev(2, 1'b0, 12, "R7");
        exp_ev(0, 1'b0, 17, "R6");
        wr(1'b1, 3'b110, 1'b1);
        repeat (15) @(negedge clk);
        wr(1'b1, 3'b111, 1'b0);
        repeat (80) @(negedge clk);
        drain("R6");
        chk("R9 busy after coincident START", int'(busy), 0);

        // R4/R5: fast START with stretch (R11)
        wr(1'b0, 3'b011, 1'b0);
        exp_ev(2, 1'b1, 6, "R5");
        exp_ev(0, 1'b1, 10, "R4");
        exp_ev(1, 1'b1, 20, "R4");
        wr(1'b1, 3'b111, 1'b1);
        drain("R4");
        run_byte(1'b1);
        exp_ev(1, 1'b0, 0, "R6");
        exp_ev(2, 1'b0, 6, "R7");
        exp_ev(0, 1'b0, 7, "R6");
        wr(1'b1, 3'b110, 1'b1);
        drain("R6 fast");

        // R10: mode change mid-sequence
        wr(1'b0, 3'b001, 1'b0);
        exp_ev(2, 1'b1, 12, "R10");
        exp_ev(0, 1'b1, 20, "R10");
        exp_ev(1, 1'b1, 40, "R10");
        wr(1'b1, 3'b111, 1'b1);
        repeat (3) @(negedge clk);
        wr(1'b0, 3'b011, 1'b0);
        drain("R10");
        run_byte(1'b0);
        exp_ev(1, 1'b0, 0, "R10");
        exp_ev(2, 1'b0, 6, "R10");
        exp_ev(0, 1'b0, 7, "R10");
        wr(1'b1, 3'b110, 1'b1);
        drain("R10 stop");
        repeat (20) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule